// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital half of an on-chip successive-approximation converter. Software writes a start bit, a channel number, a pin-configuration field and a clock-rate code. The block divides the system clock down to a conversion clock and holds the external sample-and-hold in track mode for a fixed window. It then walks a trial code on the DAC outputs from the most significant bit down, keeping or dropping each bit from the comparator answer, and stores the final code in a result register. The comparator, DAC and sample-and-hold stay outside and connect only through plain ports.

Software controls a conversion with the start bit. While the bit is high the sequencer is held cleared and busy. The conversion starts on the first clock edge that sees the bit low again. The busy flag drops when the result is written. An all-zero pin-configuration field switches the analog power off and keeps the sequencer idle. A status bit reports any change to the channel or a non-zero pin setting that has not yet been followed by a start pulse. A variant parameter sets the total conversion length to 64 or 76 conversion clocks.

Top module: `adc_seq_top`

## Requirements
- R1: The conversion clock is the system clock divided by 2 (rate code 00), by 8 (01) or by 32 (10 and 11). The code is captured on the edge where the conversion starts, and later changes do not affect that conversion.
- R2: While start_i is high and pcfg_i is non-zero, eoc_o reads 1 from the following edge onward. The conversion begins on the first edge that sees start_i low.
- R3: sample_o is high for exactly 32 conversion-clock periods at the beginning of each conversion, and low otherwise.
- R4: eoc_o drops right after the edge that closes the TOTAL-th conversion-clock period. TOTAL is 76 when LONG_VARIANT=1 and 64 otherwise, and the periods are counted from the edge that saw start_i low. With DIV system clocks per period, eoc_o is low after the (TOTAL*DIV+1)-th edge, counting that first edge as edge 1.
- R5: dac_code_o presents trial codes from the MSB down. cmp_i=1 means the input is at or above dac_code_o. The stored result equals the integer input level.
- R6: result_o changes only when a conversion completes. It keeps its value through an aborted conversion and through a power-down.
- R7: A start pulse during a conversion abandons it. eoc_o stays 1, and a complete new conversion of full length follows the new falling edge.
- R8: When pcfg_i is all zeros, ana_pwr_o is 0 from the next edge, eoc_o is 0, no conversion runs and start_i is ignored.
- R9: stale_o becomes 1 on the edge after ch_sel_i or pcfg_i changes to a different value with pcfg_i non-zero and start_i low. It is cleared by the edge after start_i is high, or when pcfg_i is zero.
- R10: After reset, eoc_o, sample_o, stale_o, ana_pwr_o, dac_code_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start bit; high clears, falling edge starts |
| ch_sel_i | input | CH_W | Analog channel number |
| pcfg_i | input | PCFG_W | Pin configuration; zero powers down |
| rate_sel_i | input | 2 | Conversion clock divider code |
| cmp_i | input | 1 | Comparator: input at or above DAC code |
| eoc_o | output | 1 | Busy / end-of-conversion flag, high while busy |
| sample_o | output | 1 | Sample-and-hold track enable |
| dac_code_o | output | RES_BITS | Trial code for the DAC |
| result_o | output | RES_BITS | Last completed conversion result |
| ana_pwr_o | output | 1 | Analog section power enable |
| stale_o | output | 1 | Configuration changed without a start pulse |

## Verification
The bench uses the default parameters: an 8-bit result, a 32-period sampling window and the 76-period variant. With these settings each bit takes five conversion clocks, and four clocks of settling follow the last decision. The comparator is modelled from an input level compared with dac_code_o, so every level from 0 to 255 can be reached, including both extreme codes. All three divide ratios are short enough that full-length conversions, aborts and power-downs complete in a few thousand cycles each.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    localparam int DIV_W = 6;

    function automatic logic [DIV_W-1:0] div_ratio(input logic [1:0] code);
        case (code)
            2'b00:   div_ratio = 6'd2;
            2'b01:   div_ratio = 6'd8;
            default: div_ratio = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/adc_rate_div.sv
module adc_rate_div
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       run_i,
    input  logic [1:0] rate_sel_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [1:0]       rate;
        logic [DIV_W-1:0] cnt;
    } div_s;

    div_s             div_d, div_q;
    logic [DIV_W-1:0] lim_m1;

    always_comb begin
        div_d  = div_q;
        lim_m1 = div_ratio(div_q.rate) - {{(DIV_W-1){1'b0}}, 1'b1};
        tick_o = run_i && (div_q.cnt == lim_m1);
        if (restart_i) begin
            div_d.rate = rate_sel_i;
            div_d.cnt  = '0;
        end else if (!run_i || tick_o) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/adc_cfg_watch.sv
module adc_cfg_watch #(
    parameter int CH_W   = 3,
    parameter int PCFG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   ch_sel_i,
    input  logic [PCFG_W-1:0] pcfg_i,
    output logic              cfg_zero_o,
    output logic              pwr_o,
    output logic              stale_o
);

    localparam int CFG_W = CH_W + PCFG_W;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             pwr;
        logic             stale;
    } watch_s;

    watch_s           w_d, w_q;
    logic [CFG_W-1:0] cfg_now;

    always_comb begin
        w_d        = w_q;
        cfg_now    = {ch_sel_i, pcfg_i};
        cfg_zero_o = (pcfg_i == '0);
        w_d.cfg    = cfg_now;
        w_d.pwr    = !cfg_zero_o;
        if (start_i || cfg_zero_o) begin
            w_d.stale = 1'b0;
        end else if (cfg_now != w_q.cfg) begin
            w_d.stale = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign pwr_o   = w_q.pwr;
    assign stale_o = w_q.stale;

    // R9
    stale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !stale_o);

    // R8
    pwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_zero_o |=> !pwr_o);

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int SAMPLE_CLKS = 32,
    parameter int TOTAL_CLKS  = 76
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cfg_zero_i,
    input  logic                tick_i,
    input  logic                cmp_i,
    output logic                restart_o,
    output logic                run_o,
    output logic                busy_o,
    output logic                sample_o,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic [RES_BITS-1:0] result_o
);

    localparam int STEP = (TOTAL_CLKS - SAMPLE_CLKS) / RES_BITS;
    localparam int TC_W = $clog2(TOTAL_CLKS + 1);
    localparam int SC_W = $clog2(STEP + 1);
    localparam int BI_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;

    typedef struct packed {
        seq_state_e          state;
        logic [TC_W-1:0]     tcnt;
        logic [SC_W-1:0]     scnt;
        logic [BI_W-1:0]     bidx;
        logic                bits_left;
        logic [RES_BITS-1:0] trial;
        logic [RES_BITS-1:0] result;
    } core_s;

    core_s               c_d, c_q;
    logic [RES_BITS-1:0] trial_nx;

    always_comb begin
        c_d       = c_q;
        restart_o = 1'b0;
        trial_nx  = c_q.trial;
        case (c_q.state)
            ST_IDLE: begin
                if (start_i) c_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (!start_i) begin
                    c_d.state     = ST_RUN;
                    restart_o     = 1'b1;
                    c_d.tcnt      = '0;
                    c_d.scnt      = '0;
                    c_d.trial     = '0;
                    c_d.bits_left = 1'b0;
                end
            end
            ST_RUN: begin
                if (start_i) begin
                    c_d.state     = ST_HOLD;
                    c_d.tcnt      = '0;
                    c_d.trial     = '0;
                    c_d.bits_left = 1'b0;
                end else if (tick_i) begin
                    if (c_q.bits_left) begin
                        if (c_q.scnt == SC_W'(STEP - 1)) begin
                            trial_nx[c_q.bidx] = cmp_i;
                            if (c_q.bidx != '0) begin
                                trial_nx[c_q.bidx - 1'b1] = 1'b1;
                                c_d.bidx = c_q.bidx - 1'b1;
                            end else begin
                                c_d.bits_left = 1'b0;
                            end
                            c_d.scnt = '0;
                        end else begin
                            c_d.scnt = c_q.scnt + 1'b1;
                        end
                    end
                    if (c_q.tcnt == TC_W'(SAMPLE_CLKS - 1)) begin
                        trial_nx      = '0;
                        trial_nx[RES_BITS-1] = 1'b1;
                        c_d.bidx      = BI_W'(RES_BITS - 1);
                        c_d.bits_left = 1'b1;
                        c_d.scnt      = '0;
                    end
                    c_d.trial = trial_nx;
                    if (c_q.tcnt == TC_W'(TOTAL_CLKS - 1)) begin
                        c_d.state     = ST_IDLE;
                        c_d.result    = trial_nx;
                        c_d.tcnt      = '0;
                        c_d.trial     = '0;
                        c_d.bits_left = 1'b0;
                    end else begin
                        c_d.tcnt = c_q.tcnt + 1'b1;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
        if (cfg_zero_i) begin
            c_d.state     = ST_IDLE;
            c_d.tcnt      = '0;
            c_d.trial     = '0;
            c_d.bits_left = 1'b0;
            restart_o     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy_o     = (c_q.state != ST_IDLE);
    assign run_o      = (c_q.state == ST_RUN);
    assign sample_o   = run_o && (c_q.tcnt < TC_W'(SAMPLE_CLKS));
    assign dac_code_o = c_q.trial;
    assign result_o   = c_q.result;

    // R2
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cfg_zero_i) |=> (c_q.state == ST_HOLD));

    // R4
    tcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.tcnt < TC_W'(TOTAL_CLKS));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state != ST_RUN) |=> $stable(c_q.result));

    // R8
    pwr_down_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_zero_i |=> !busy_o);

    // R3
    sample_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sample_o);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int RES_BITS     = 8,
    parameter int CH_W         = 3,
    parameter int PCFG_W       = 3,
    parameter int SAMPLE_CLKS  = 32,
    parameter bit LONG_VARIANT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CH_W-1:0]     ch_sel_i,
    input  logic [PCFG_W-1:0]   pcfg_i,
    input  logic [1:0]          rate_sel_i,
    input  logic                cmp_i,
    output logic                eoc_o,
    output logic                sample_o,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                ana_pwr_o,
    output logic                stale_o
);

    localparam int TOTAL_CLKS = LONG_VARIANT ? 76 : 64;

    logic cfg_zero;
    logic restart;
    logic run;
    logic tick;

    adc_cfg_watch #(
        .CH_W   (CH_W),
        .PCFG_W (PCFG_W)
    ) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ch_sel_i   (ch_sel_i),
        .pcfg_i     (pcfg_i),
        .cfg_zero_o (cfg_zero),
        .pwr_o      (ana_pwr_o),
        .stale_o    (stale_o)
    );

    adc_rate_div u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .run_i      (run),
        .rate_sel_i (rate_sel_i),
        .tick_o     (tick)
    );

    adc_sar_core #(
        .RES_BITS    (RES_BITS),
        .SAMPLE_CLKS (SAMPLE_CLKS),
        .TOTAL_CLKS  (TOTAL_CLKS)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cfg_zero_i (cfg_zero),
        .tick_i     (tick),
        .cmp_i      (cmp_i),
        .restart_o  (restart),
        .run_o      (run),
        .busy_o     (eoc_o),
        .sample_o   (sample_o),
        .dac_code_o (dac_code_o),
        .result_o   (result_o)
    );

endmodule

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;

    localparam int TOTAL  = 76;
    localparam int SAMPLE = 32;
    localparam int NVEC   = 6;

    localparam int T_RATE [NVEC] = '{0, 1, 2, 3, 0, 1};
    localparam int T_VIN  [NVEC] = '{0, 255, 128, 127, 85, 170};
    localparam int T_CH   [NVEC] = '{1, 2, 3, 4, 5, 6};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] ch = '0;
    logic [2:0] pcfg = '0;
    logic [1:0] rate = '0;
    logic [7:0] vin = '0;
    logic       cmp;
    logic       eoc, samp, pwr, stale;
    logic [7:0] dac, res;

    int checks = 0;
    int errors = 0;
    int wd = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign cmp = (vin >= dac);

    adc_seq_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .ch_sel_i   (ch),
        .pcfg_i     (pcfg),
        .rate_sel_i (rate),
        .cmp_i      (cmp),
        .eoc_o      (eoc),
        .sample_o   (samp),
        .dac_code_o (dac),
        .result_o   (res),
        .ana_pwr_o  (pwr),
        .stale_o    (stale)
    );

    function automatic int exp_div(input int r);
        if (r == 0) return 2;
        if (r == 1) return 8;
        return 32;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk);
        @(negedge clk) start = 1'b0;
    endtask

    task automatic measure(output int cyc, output int scnt);
        cyc = 0;
        scnt = 0;
        do begin
            @(posedge clk);
            #1;
            cyc++;
            if (samp) scnt++;
        end while (eoc && cyc < 5000);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual %0d expected below 150000", wd);
            summary();
        end
    end

    initial begin
        int cyc, sc, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(eoc == 0 && samp == 0 && stale == 0, "R10 flags", {eoc, samp, stale}, 0);
        check(pwr == 0 && dac == 0 && res == 0, "R10 data", res, 0);

        pcfg = 3'b001;
        @(negedge clk);
        check(pwr == 1, "R8 power on", pwr, 1);
        check(stale == 1, "R9 stale on config change", stale, 1);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            rate = 2'(T_RATE[i]);
            vin  = 8'(T_VIN[i]);
            ch   = 3'(T_CH[i]);
            start = 1'b1;
            @(negedge clk);
            check(eoc == 1, "R2 busy while start high", eoc, 1);
            check(stale == 0, "R9 start clears stale", stale, 0);
            @(negedge clk) start = 1'b0;
            measure(cyc, sc);
            check(cyc == TOTAL * exp_div(T_RATE[i]) + 1, "R4 R1 conversion time", cyc,
                  TOTAL * exp_div(T_RATE[i]) + 1);
            check(sc == SAMPLE * exp_div(T_RATE[i]), "R3 sampling window", sc,
                  SAMPLE * exp_div(T_RATE[i]));
            check(res == 8'(T_VIN[i]), "R5 result", res, T_VIN[i]);
        end

        // R7 abort and restart; R6 result held through abort
        prev = int'(res);
        rate = 2'b01;
        vin  = 8'd200;
        pulse_start();
        repeat (100) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check(eoc == 1, "R7 busy across abort", eoc, 1);
        check(int'(res) == prev, "R6 result kept on abort", res, prev);
        start = 1'b0;
        measure(cyc, sc);
        check(cyc == TOTAL * 8 + 1, "R7 full length after restart", cyc, TOTAL * 8 + 1);
        check(res == 8'd200, "R7 result after restart", res, 200);

        // R1 rate captured at start
        rate = 2'b00;
        vin  = 8'd33;
        pulse_start();
        @(negedge clk) rate = 2'b10;
        measure(cyc, sc);
        check(cyc == TOTAL * 2, "R1 rate latched", cyc, TOTAL * 2);
        check(res == 8'd33, "R5 result low code", res, 33);

        // R8 power-down mid conversion; R6 result held
        prev = int'(res);
        rate = 2'b01;
        vin  = 8'd99;
        pulse_start();
        repeat (50) @(negedge clk);
        pcfg = 3'b000;
        @(negedge clk);
        check(eoc == 0 && pwr == 0, "R8 power down idles", {eoc, pwr}, 0);
        check(int'(res) == prev, "R6 result kept on power down", res, prev);
        start = 1'b1;
        @(negedge clk);
        check(eoc == 0, "R8 start ignored when off", eoc, 0);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(eoc == 0 && samp == 0, "R8 no conversion when off", eoc, 0);
        pcfg = 3'b101;
        @(negedge clk);
        check(stale == 1, "R9 stale after re-enable", stale, 1);
        ch = 3'd0;
        @(negedge clk);
        check(stale == 1, "R9 stale stays set", stale, 1);
        pcfg = 3'b000;
        @(negedge clk);
        check(stale == 0, "R9 zero config clears stale", stale, 0);

        summary();
    end

endmodule